// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Bus Master

This block is the transmit/receive engine of a serial peripheral bus master that moves one byte per transfer. Writing a byte through the write strobe starts a full-duplex exchange. The byte leaves on `mosi` while a byte from the peripheral arrives on `miso`. The engine drives the serial clock and one active-low select line for the whole exchange.

When the exchange ends, the received byte is placed in a receive buffer and a completion flag is raised. A read strobe takes the byte and clears the flags. Two settings are captured when a transfer starts: a 3-bit divider that sets the serial clock rate, and a bit-order control that picks whether bit 7 or bit 0 goes first. A write made while a transfer is in flight does nothing except raise a collision flag.

The bus runs in mode 0. The clock rests low, each data bit is captured on a rising edge, and outgoing data changes after each falling edge.

Top module: `spim_engine`

## Requirements
- R1: After reset, `sel_n`=1, `sclk`=0, `busy`=0, `done`=0 and `wcol`=0.
- R2: A `wr_en` pulse while idle starts a transfer with exactly 8 rising `sclk` edges. `sel_n` is low throughout and `busy` is high until the transfer ends.
- R3: With `lsb_first`=0, the bit on `mosi` at the k-th rising edge (k=0..7) is `wr_data[7-k]`. The `miso` bit sampled at the k-th rising edge lands in received bit 7-k.
- R4: With `lsb_first`=1, the bit on `mosi` at the k-th rising edge is `wr_data[k]`. The `miso` bit sampled at the k-th rising edge lands in received bit k.
- R5: `sclk` is low whenever the engine is idle. `mosi` changes only when a transfer is loaded or on a falling `sclk` edge.
- R6: With divider value N on `div_sel`, each half period of `sclk` lasts N+1 clock cycles. `div_sel` and `lsb_first` are sampled only when a transfer starts.
- R7: `sel_n` falls N+1 cycles before the first rising `sclk` edge and rises N+1 cycles after the last falling edge, so it stays low for 17*(N+1) cycles. `sclk` is never high while `sel_n` is high.
- R8: At the end of a transfer, the received byte appears on `rd_data` and `done` is set, in the same cycle that `sel_n` returns high.
- R9: An `rd_en` pulse clears `done` and `wcol`, and `rd_data` keeps its value.
- R10: A `wr_en` pulse during a transfer does not change the bits sent, the timing or the byte received, and it sets `wcol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: starts a transfer when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe: clears done and wcol |
| rd_data | output | 8 | Receive buffer |
| lsb_first | input | 1 | 1 selects bit 0 first, 0 selects bit 7 first |
| div_sel | input | 3 | Divider N; half period of sclk is N+1 clocks |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Receive buffer holds a new byte |
| wcol | output | 1 | Write arrived during a transfer |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| sel_n | output | 1 | Active-low peripheral select |

## Verification
The bench acts as the peripheral. It sends a known byte in the same bit order as the engine, while it captures `mosi` on rising edges and counts clock cycles between select and clock edges.

It runs the smallest and largest divider values, both bit orders, and bytes whose bits are not symmetric. An engine that reversed the fill direction, or shifted one bit too many or too few, would return a mirrored or rotated byte. A divider that was off by one would show up in the lead-in and half-period counts.

Mid-transfer writes also change `div_sel` and the data. An engine that accepted them would send the wrong bits, stretch the timing, or fail to raise `wcol`. A read after each transfer confirms that both flags clear.

// File: rtl/spim_pkg.sv
package spim_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } spim_state_e;
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R6: counter never passes the captured divider value
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= div));
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         rise,
  input  logic         fall,
  input  logic         miso,
  output logic         mosi,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] sr;
  logic [W-1:0] sr_nxt;
  logic         lsb_q;
  logic         rbit;

  always_comb begin
    if (lsb_q) sr_nxt = {rbit, sr[W-1:1]};
    else       sr_nxt = {sr[W-2:0], rbit};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      lsb_q <= 1'b0;
      rbit  <= 1'b0;
      mosi  <= 1'b0;
    end else if (load) begin
      sr    <= load_data;
      lsb_q <= lsb_first;
      mosi  <= lsb_first ? load_data[0] : load_data[W-1];
    end else begin
      if (rise) rbit <= miso;
      if (fall) begin
        sr   <= sr_nxt;
        mosi <= lsb_q ? sr_nxt[0] : sr_nxt[W-1];
      end
    end
  end

  assign rx_word = sr;

  // R5: outgoing data moves only on load or a falling edge
  a_r5_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !fall) |=> $stable(mosi));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl #(
  parameter int W     = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tick,
  output logic [DIV_W-1:0] div_q,
  output logic             run,
  output logic             rise,
  output logic             fall,
  output logic             finish,
  output logic             sclk,
  output logic             sel_n
);
  import spim_pkg::*;

  localparam int EDGES = 2 * W;
  localparam int EW    = $clog2(EDGES + 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);

  spim_state_e   state;
  logic [EW-1:0] edge_cnt;

  assign run    = (state != ST_IDLE);
  assign rise   = tick && ((state == ST_LEAD) || ((state == ST_SHIFT) && !sclk));
  assign fall   = tick && (state == ST_SHIFT) && sclk;
  assign finish = tick && (state == ST_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      edge_cnt <= '0;
      div_q    <= '0;
      sclk     <= 1'b0;
      sel_n    <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_LEAD;
          sel_n    <= 1'b0;
          div_q    <= div_in;
          edge_cnt <= '0;
        end
        ST_LEAD: if (tick) begin
          state    <= ST_SHIFT;
          sclk     <= 1'b1;
          edge_cnt <= EW'(1);
        end
        ST_SHIFT: if (tick) begin
          sclk     <= ~sclk;
          edge_cnt <= edge_cnt + 1'b1;
          if (edge_cnt == EDGE_LAST) state <= ST_TRAIL;
        end
        default: if (tick) begin
          state <= ST_IDLE;
          sel_n <= 1'b1;
        end
      endcase
    end
  end

  // R7: clock only pulses while the select is asserted
  a_r7_sclk_in_sel: assert property (@(posedge clk) disable iff (rst)
    sclk |-> !sel_n);
  // R5: clock rests low when idle
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sclk);
  // R6: clock moves only on a divider tick
  a_r6_sclk_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sclk));
endmodule

// File: rtl/spim_engine.sv
module spim_engine #(
  parameter int W     = 8,
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_en,
  output logic [W-1:0]     rd_data,
  input  logic             lsb_first,
  input  logic [DIV_W-1:0] div_sel,
  output logic             busy,
  output logic             done,
  output logic             wcol,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             sel_n
);
  logic             start;
  logic             tick;
  logic             run;
  logic             rise;
  logic             fall;
  logic             finish;
  logic [DIV_W-1:0] div_q;
  logic [W-1:0]     rx_word;

  assign busy  = run;
  assign start = wr_en && !run;

  spim_ctrl #(.W(W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .div_in(div_sel), .tick(tick),
    .div_q(div_q), .run(run), .rise(rise), .fall(fall), .finish(finish),
    .sclk(sclk), .sel_n(sel_n)
  );

  spim_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(run), .div(div_q), .tick(tick)
  );

  spim_shift #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .load(start), .load_data(wr_data),
    .lsb_first(lsb_first), .rise(rise), .fall(fall), .miso(miso),
    .mosi(mosi), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      done    <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      if (finish) begin
        rd_data <= rx_word;
        done    <= 1'b1;
      end else if (rd_en) begin
        done <= 1'b0;
      end
      if (wr_en && run) wcol <= 1'b1;
      else if (rd_en)   wcol <= 1'b0;
    end
  end

  // R10: a write during a transfer raises the collision flag
  a_r10_wcol_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> wcol);
  // R9: a read clears the collision flag
  a_r9_wcol_clr: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && busy)) |=> !wcol);
  // R8: completion raises done
  a_r8_done_set: assert property (@(posedge clk) disable iff (rst)
    finish |=> (done && sel_n));
  // R9: a read clears done
  a_r9_done_clr: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !finish) |=> !done);
endmodule

// File: tb/sim_spim_engine.sv
module sim_spim_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       lsb_first = 1'b0;
  logic [2:0] div_sel = '0;
  logic       busy, done, wcol, sclk, mosi, sel_n;
  logic       miso = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  spim_engine u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .lsb_first(lsb_first), .div_sel(div_sel), .busy(busy),
    .done(done), .wcol(wcol), .sclk(sclk), .mosi(mosi), .miso(miso),
    .sel_n(sel_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(sel_n == 1'b1, "R1 sel_n", sel_n, 1);
    check(sclk == 1'b0, "R1 sclk", sclk, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(wcol == 1'b0, "R1 wcol", wcol, 0);
  endtask

  // One transfer with the bench acting as the peripheral
  task automatic t_xfer(input logic [7:0] tx, input logic [7:0] sl,
                        input bit lsb, input logic [2:0] dv, input bit collide);
    int cyc = 0, rises = 0, falls = 0, first_rise = -1, sel_end = -1;
    int hi_start = 0, hi_len = -1, sidx = 0;
    logic prev = 1'b0;
    logic [7:0] got = '0;
    int half = int'(dv) + 1;
    wr_data = tx; lsb_first = lsb; div_sel = dv; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(sel_n == 1'b0 && busy == 1'b1, "R2 start", {sel_n, busy}, 1);
    miso = lsb ? sl[0] : sl[7];
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (collide && cyc == 3) begin
        wr_en = 1'b1; wr_data = ~tx; div_sel = ~dv; lsb_first = ~lsb;
      end else if (collide && cyc == 4) begin
        wr_en = 1'b0;
      end
      if (sclk && !prev) begin
        if (rises == 0) first_rise = cyc;
        if (rises < 8) got[lsb ? rises : 7 - rises] = mosi;
        rises++;
        hi_start = cyc;
      end
      if (!sclk && prev) begin
        falls++;
        hi_len = cyc - hi_start;
        sidx++;
        if (sidx < 8) miso = lsb ? sl[sidx] : sl[7 - sidx];
      end
      if (sel_n && sel_end < 0) sel_end = cyc;
      prev = sclk;
    end
    check(rises == 8, "R2 rising edge count", rises, 8);
    check(falls == 8, "R2 falling edge count", falls, 8);
    check(got == tx, lsb ? "R4 mosi order" : "R3 mosi order", got, tx);
    check(rd_data == sl, lsb ? "R4 received byte" : "R3 received byte", rd_data, sl);
    check(first_rise == half, "R7 lead-in", first_rise, half);
    check(hi_len == half, "R6 half period", hi_len, half);
    check(sel_end == 17 * half, "R7 select length", sel_end, 17 * half);
    check(done == 1'b1 && sel_n == 1'b1, "R8 done with select release", {done, sel_n}, 3);
    check(busy == 1'b0 && sclk == 1'b0, "R5 idle clock low", {busy, sclk}, 0);
    check(wcol == collide, "R10 collision flag", wcol, collide);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && wcol == 1'b0, "R9 read clears flags", {done, wcol}, 0);
    check(rd_data == sl, "R9 buffer kept", rd_data, sl);
  endtask

  initial begin
    #(20 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_xfer(8'hA5, 8'h3C, 1'b0, 3'd0, 1'b0);  // R3 msb first, fastest clock
    t_xfer(8'h2D, 8'hC1, 1'b1, 3'd2, 1'b0);  // R4 lsb first
    t_xfer(8'h81, 8'h7E, 1'b0, 3'd7, 1'b1);  // R10 R6 collision, slowest clock
    t_xfer(8'h96, 8'h0E, 1'b1, 3'd1, 1'b1);  // R10 collision in lsb mode
    t_xfer(8'h01, 8'hF0, 1'b0, 3'd3, 1'b0);  // R8 buffer updated again
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule